// File: doc/BRIEF.md
# SIMT Divergence and Reconvergence Stack with Call Frames

This block keeps the control-flow state of one warp in a SIMT core. Each entry records a program counter, a reconvergence PC, a per-lane active mask and an entry kind, either plain or call frame. The top entry is always on the outputs. The fetch stage reads it to learn where the warp runs next and which lanes take part.

After each instruction the core sends one update. The update carries the lanes that finished, the next PC of every lane, the reconvergence PC of the branch just executed, and the class of the next instruction: plain, call or return. The stack splits the warp on divergence and pops entries as their lanes reconverge. It pushes a call frame on a call and unwinds that frame on a return. A call frame on top stops reconvergence popping, so lanes inside a called function never merge with entries from outside it. A launch command starts the warp at a given PC with a given lane mask. The capacity is four entries per lane. Pushes past the capacity and pops below the bottom entry are refused and reported.

Top module: `simt_reconv_stack`

## Requirements
- R1: After reset the depth is 0 and the bottom entry is on top with PC and reconvergence PC all ones, an empty lane mask and the plain kind (top_call_o = 0).
- R2: A launch writes entry 0 with the given PC and mask, a reconvergence PC of all ones and the plain kind, and sets the depth to 0. A launch takes priority over an update in the same cycle.
- R3: In an update of class plain (op 2'b00, or the unused code 2'b11), the active lanes are the top mask with the done lanes cleared. If all active lanes share one next PC and that PC is not removed by R5, only the top PC changes, to that next PC.
- R4: When the surviving next-PC groups do not all cover every active lane, the top entry's PC becomes the update's reconvergence PC. One plain entry is then pushed per group, with that group's lanes as its mask and the update's reconvergence PC as its reconvergence PC. Groups are ordered by their lowest lane, so the group with the highest leading lane ends up on top. The depth grows by the number of groups and diverge_o pulses high for one cycle.
- R5: When the top entry is plain, any group whose next PC equals the top reconvergence PC is dropped. If no group survives, including the case where no lane is active, the top entry is popped.
- R6: A call update (op 2'b01) pushes one entry of the call kind. Its PC is the next PC of the lowest active lane (lane 0 if none is active), its mask is the active lanes and its reconvergence PC is all ones. The entry below keeps its contents.
- R7: When the top entry is a call frame, a plain update never drops a group, even one whose PC equals the top reconvergence PC.
- R8: A return update (op 2'b10) with a call frame on top pops that frame and sets the new top's PC to the return PC, which is the next PC of the lowest active lane. If that PC equals the new top's reconvergence PC and the new top is plain, that entry is popped as well in the same update.
- R9: A return update with a plain entry on top is handled exactly like a plain update.
- R10: A push that would go past entry 4*LANES-1 changes nothing and pulses overflow_o for one cycle, with no diverge pulse.
- R11: A pop below entry 0 is not performed. The depth stays 0 and underflow_o pulses for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| launch_i | input | 1 | Start the warp from a given PC and mask |
| launch_pc_i | input | PC_W | Start PC for a launch |
| launch_mask_i | input | LANES | Initial lane mask for a launch |
| upd_i | input | 1 | Update request after an instruction |
| done_mask_i | input | LANES | Lanes that have finished |
| next_pc_i | input | LANES*PC_W | Next PC per lane, lane 0 in the low bits |
| recv_pc_i | input | PC_W | Reconvergence PC of the executed branch |
| op_i | input | 2 | Next instruction class: 00 plain, 01 call, 10 return |
| top_pc_o | output | PC_W | PC of the top entry |
| top_rpc_o | output | PC_W | Reconvergence PC of the top entry |
| top_mask_o | output | LANES | Active lane mask of the top entry |
| top_call_o | output | 1 | Top entry is a call frame |
| depth_o | output | $clog2(4*LANES) | Index of the top entry |
| diverge_o | output | 1 | One-cycle pulse after a divergent update |
| overflow_o | output | 1 | One-cycle pulse after a refused push |
| underflow_o | output | 1 | One-cycle pulse after a refused pop |

## Verification
Every update or launch is applied at one rising edge. The top-entry outputs and the depth come straight from the registered stack, so they take their new values right after that edge. The three pulses are registered at the same edge and stay high for exactly that one cycle. The bench drives each request on a falling edge, holds it for one cycle, and compares all outputs with its model on the next falling edge. At that point both the stack state and the pulses belong to that single request.

// File: rtl/simt_stack_pkg.sv
package simt_stack_pkg;
  typedef enum logic [1:0] {
    OP_PLAIN = 2'b00,
    OP_CALL  = 2'b01,
    OP_RET   = 2'b10,
    OP_SPARE = 2'b11
  } op_class_e;

  typedef enum logic {
    KIND_PLAIN = 1'b0,
    KIND_CALL  = 1'b1
  } entry_kind_e;
endpackage

// File: rtl/simt_lane_grouper.sv
module simt_lane_grouper #(
  parameter int LANES = 4,
  parameter int PC_W  = 16,
  localparam int CNT_W = $clog2(LANES + 1)
) (
  input  logic [LANES-1:0]       act_i,
  input  logic [LANES*PC_W-1:0]  lane_pc_i,
  input  logic [PC_W-1:0]        cmp_pc_i,
  input  logic                   drop_en_i,
  output logic [CNT_W-1:0]       grp_cnt_o,
  output logic [LANES*PC_W-1:0]  grp_pc_o,
  output logic [LANES*LANES-1:0] grp_mask_o,
  output logic                   partial_o,
  output logic [PC_W-1:0]        first_pc_o
);
  logic [PC_W-1:0]  pcs    [LANES];
  logic [LANES-1:0] same   [LANES];
  logic [LANES-1:0] leader;
  logic [LANES-1:0] keep;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign pcs[i] = lane_pc_i[i*PC_W +: PC_W];
    for (genvar j = 0; j < LANES; j++) begin : g_cmp
      assign same[i][j] = act_i[j] && (pcs[j] == pcs[i]);
    end
    if (i == 0) begin : g_first
      assign leader[i] = act_i[i];
    end else begin : g_rest
      assign leader[i] = act_i[i] && (same[i][i-1:0] == '0);
    end
    assign keep[i] = leader[i] && !(drop_en_i && (pcs[i] == cmp_pc_i));
  end

  always_comb begin
    grp_cnt_o  = '0;
    grp_pc_o   = '0;
    grp_mask_o = '0;
    partial_o  = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      if (keep[i]) begin
        grp_pc_o[int'(grp_cnt_o)*PC_W +: PC_W]    = pcs[i];
        grp_mask_o[int'(grp_cnt_o)*LANES +: LANES] = same[i];
        grp_cnt_o = grp_cnt_o + 1'b1;
        if (same[i] != act_i) partial_o = 1'b1;
      end
    end
  end

  always_comb begin
    first_pc_o = pcs[0];
    for (int i = LANES - 1; i >= 0; i--) begin
      if (act_i[i]) first_pc_o = pcs[i];
    end
  end
endmodule

// File: rtl/simt_stack_regs.sv
module simt_stack_regs #(
  parameter int DEPTH = 16,
  parameter int LANES = 4,
  parameter int PC_W  = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [DEPTH-1:0]       wen_i,
  input  logic [DEPTH*PC_W-1:0]  d_pc_i,
  input  logic [DEPTH*PC_W-1:0]  d_rpc_i,
  input  logic [DEPTH*LANES-1:0] d_mask_i,
  input  logic [DEPTH-1:0]       d_kind_i,
  output logic [DEPTH*PC_W-1:0]  q_pc_o,
  output logic [DEPTH*PC_W-1:0]  q_rpc_o,
  output logic [DEPTH*LANES-1:0] q_mask_o,
  output logic [DEPTH-1:0]       q_kind_o
);
  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q_pc_o[e*PC_W +: PC_W]    <= '1;
        q_rpc_o[e*PC_W +: PC_W]   <= '1;
        q_mask_o[e*LANES +: LANES] <= '0;
        q_kind_o[e]               <= 1'b0;
      end else if (wen_i[e]) begin
        q_pc_o[e*PC_W +: PC_W]    <= d_pc_i[e*PC_W +: PC_W];
        q_rpc_o[e*PC_W +: PC_W]   <= d_rpc_i[e*PC_W +: PC_W];
        q_mask_o[e*LANES +: LANES] <= d_mask_i[e*LANES +: LANES];
        q_kind_o[e]               <= d_kind_i[e];
      end
    end
  end
endmodule

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack
  import simt_stack_pkg::*;
#(
  parameter int LANES = 4,
  parameter int PC_W  = 16,
  localparam int DEPTH = 4 * LANES,
  localparam int SP_W  = $clog2(DEPTH),
  localparam int CNT_W = $clog2(LANES + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  launch_i,
  input  logic [PC_W-1:0]       launch_pc_i,
  input  logic [LANES-1:0]      launch_mask_i,
  input  logic                  upd_i,
  input  logic [LANES-1:0]      done_mask_i,
  input  logic [LANES*PC_W-1:0] next_pc_i,
  input  logic [PC_W-1:0]       recv_pc_i,
  input  logic [1:0]            op_i,
  output logic [PC_W-1:0]       top_pc_o,
  output logic [PC_W-1:0]       top_rpc_o,
  output logic [LANES-1:0]      top_mask_o,
  output logic                  top_call_o,
  output logic [SP_W-1:0]       depth_o,
  output logic                  diverge_o,
  output logic                  overflow_o,
  output logic                  underflow_o
);
  logic [DEPTH*PC_W-1:0]  q_pc, q_rpc, n_pc, n_rpc;
  logic [DEPTH*LANES-1:0] q_mask, n_mask;
  logic [DEPTH-1:0]       q_kind, n_kind, wen;
  logic [SP_W-1:0]        sp_q, sp_n;
  logic                   div_n, ovf_n, unf_n;

  logic [LANES-1:0]       active;
  logic [CNT_W-1:0]       grp_cnt;
  logic [LANES*PC_W-1:0]  grp_pc;
  logic [LANES*LANES-1:0] grp_mask;
  logic                   partial;
  logic [PC_W-1:0]        first_pc;
  op_class_e              op;

  assign op         = op_class_e'(op_i);
  assign top_pc_o   = q_pc[int'(sp_q)*PC_W +: PC_W];
  assign top_rpc_o  = q_rpc[int'(sp_q)*PC_W +: PC_W];
  assign top_mask_o = q_mask[int'(sp_q)*LANES +: LANES];
  assign top_call_o = q_kind[sp_q];
  assign depth_o    = sp_q;
  assign active     = top_mask_o & ~done_mask_i;

  simt_lane_grouper #(.LANES(LANES), .PC_W(PC_W)) grouper_i (
    .act_i      (active),
    .lane_pc_i  (next_pc_i),
    .cmp_pc_i   (top_rpc_o),
    .drop_en_i  (!top_call_o),
    .grp_cnt_o  (grp_cnt),
    .grp_pc_o   (grp_pc),
    .grp_mask_o (grp_mask),
    .partial_o  (partial),
    .first_pc_o (first_pc)
  );

  simt_stack_regs #(.DEPTH(DEPTH), .LANES(LANES), .PC_W(PC_W)) regs_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wen_i    (wen),
    .d_pc_i   (n_pc),
    .d_rpc_i  (n_rpc),
    .d_mask_i (n_mask),
    .d_kind_i (n_kind),
    .q_pc_o   (q_pc),
    .q_rpc_o  (q_rpc),
    .q_mask_o (q_mask),
    .q_kind_o (q_kind)
  );

  // next-state of stack contents, pointer and pulses
  always_comb begin
    int top, below, slot;
    n_pc   = q_pc;
    n_rpc  = q_rpc;
    n_mask = q_mask;
    n_kind = q_kind;
    wen    = '0;
    sp_n   = sp_q;
    div_n  = 1'b0;
    ovf_n  = 1'b0;
    unf_n  = 1'b0;
    top    = int'(sp_q);
    below  = (top > 0) ? top - 1 : 0;
    slot   = 0;
    if (launch_i) begin
      n_pc[0 +: PC_W]    = launch_pc_i;
      n_rpc[0 +: PC_W]   = '1;
      n_mask[0 +: LANES] = launch_mask_i;
      n_kind[0]          = KIND_PLAIN;
      wen[0]             = 1'b1;
      sp_n               = '0;
    end else if (upd_i) begin
      if (op == OP_CALL) begin
        if (top == DEPTH - 1) begin
          ovf_n = 1'b1;
        end else begin
          n_pc[(top+1)*PC_W +: PC_W]     = first_pc;
          n_rpc[(top+1)*PC_W +: PC_W]    = '1;
          n_mask[(top+1)*LANES +: LANES] = active;
          n_kind[top+1]                  = KIND_CALL;
          wen[top+1]                     = 1'b1;
          sp_n                           = SP_W'(top + 1);
        end
      end else if (op == OP_RET && top_call_o) begin
        if (top == 0) begin
          unf_n = 1'b1;
        end else begin
          n_kind[top]                = KIND_PLAIN;
          wen[top]                   = 1'b1;
          n_pc[below*PC_W +: PC_W]   = first_pc;
          wen[below]                 = 1'b1;
          sp_n                       = SP_W'(below);
          if (first_pc == q_rpc[below*PC_W +: PC_W] && !q_kind[below]) begin
            if (below == 0) unf_n = 1'b1;
            else            sp_n  = SP_W'(below - 1);
          end
        end
      end else if (grp_cnt == '0) begin
        if (top == 0) unf_n = 1'b1;
        else          sp_n  = SP_W'(top - 1);
      end else if (!partial) begin
        n_pc[top*PC_W +: PC_W] = grp_pc[0 +: PC_W];
        wen[top]               = 1'b1;
      end else if (top + int'(grp_cnt) > DEPTH - 1) begin
        ovf_n = 1'b1;
      end else begin
        n_pc[top*PC_W +: PC_W] = recv_pc_i;
        wen[top]               = 1'b1;
        for (int k = 0; k < LANES; k++) begin
          if (k < int'(grp_cnt)) begin
            slot                        = top + 1 + k;
            n_pc[slot*PC_W +: PC_W]     = grp_pc[k*PC_W +: PC_W];
            n_rpc[slot*PC_W +: PC_W]    = recv_pc_i;
            n_mask[slot*LANES +: LANES] = grp_mask[k*LANES +: LANES];
            n_kind[slot]                = KIND_PLAIN;
            wen[slot]                   = 1'b1;
          end
        end
        sp_n  = SP_W'(top + int'(grp_cnt));
        div_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q        <= '0;
      diverge_o   <= 1'b0;
      overflow_o  <= 1'b0;
      underflow_o <= 1'b0;
    end else begin
      sp_q        <= sp_n;
      diverge_o   <= div_n;
      overflow_o  <= ovf_n;
      underflow_o <= unf_n;
    end
  end
endmodule

// File: rtl/simt_reconv_stack_chk.sv
module simt_reconv_stack_chk #(
  parameter int PC_W = 16,
  parameter int SP_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PC_W-1:0] top_rpc_o,
  input logic            top_call_o,
  input logic [SP_W-1:0] depth_o,
  input logic            diverge_o,
  input logic            overflow_o,
  input logic            underflow_o
);
  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |-> (depth_o == $past(depth_o)) && !diverge_o);
  // R4
  div_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    diverge_o |-> depth_o > $past(depth_o));
  // R11
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_o |-> depth_o == '0);
  // R6
  call_rpc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    top_call_o |-> top_rpc_o == '1);
  // R11
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({diverge_o, overflow_o, underflow_o}) <= 1);
endmodule

bind simt_reconv_stack simt_reconv_stack_chk #(.PC_W(PC_W), .SP_W(SP_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .top_rpc_o   (top_rpc_o),
  .top_call_o  (top_call_o),
  .depth_o     (depth_o),
  .diverge_o   (diverge_o),
  .overflow_o  (overflow_o),
  .underflow_o (underflow_o)
);

// File: tb/simt_reconv_stack_tb.sv
module simt_reconv_stack_tb_top;
  localparam int L = 4;
  localparam int W = 16;
  localparam int D = 4 * L;

  logic clk, rst_n;
  logic launch_i, upd_i;
  logic [W-1:0] launch_pc_i, recv_pc_i;
  logic [L-1:0] launch_mask_i, done_mask_i;
  logic [L*W-1:0] next_pc_i;
  logic [1:0] op_i;
  logic [W-1:0] top_pc_o, top_rpc_o;
  logic [L-1:0] top_mask_o;
  logic top_call_o, diverge_o, overflow_o, underflow_o;
  logic [3:0] depth_o;

  int n_chk = 0;
  int n_bad = 0;

  logic [W-1:0] m_pc [D];
  logic [W-1:0] m_rpc[D];
  logic [L-1:0] m_mask[D];
  logic         m_kind[D];
  int           m_sp;
  logic         e_div, e_ovf, e_unf;
  string        cur_req;
  logic [W-1:0] stim_pc[L];

  simt_reconv_stack #(.LANES(L), .PC_W(W)) dut_i (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    report();
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_all(string req);
    chk(req, "top_pc", 32'(top_pc_o), 32'(m_pc[m_sp]));
    chk(req, "top_rpc", 32'(top_rpc_o), 32'(m_rpc[m_sp]));
    chk(req, "top_mask", 32'(top_mask_o), 32'(m_mask[m_sp]));
    chk(req, "top_call", 32'(top_call_o), 32'(m_kind[m_sp]));
    chk(req, "depth", 32'(depth_o), 32'(m_sp));
    chk(req, "diverge", 32'(diverge_o), 32'(e_div));
    chk(req, "overflow", 32'(overflow_o), 32'(e_ovf));
    chk(req, "underflow", 32'(underflow_o), 32'(e_unf));
  endtask

  task automatic m_reset();
    for (int e = 0; e < D; e++) begin
      m_pc[e] = '1; m_rpc[e] = '1; m_mask[e] = '0; m_kind[e] = 1'b0;
    end
    m_sp = 0; e_div = 0; e_ovf = 0; e_unf = 0;
  endtask

  // Reference model written from the requirements
  task automatic m_update(logic [L-1:0] done, logic [W-1:0] rv, logic [1:0] op);
    logic [L-1:0] act, gm[L];
    logic [W-1:0] first, gp[L];
    int g, b;
    logic part, dup;
    e_div = 0; e_ovf = 0; e_unf = 0;
    act = m_mask[m_sp] & ~done;
    first = stim_pc[0];
    for (int i = L - 1; i >= 0; i--) if (act[i]) first = stim_pc[i];
    if (op == 2'b01) begin
      cur_req = "R6";
      if (m_sp == D - 1) begin e_ovf = 1; cur_req = "R10"; end
      else begin
        m_sp++; m_pc[m_sp] = first; m_rpc[m_sp] = '1; m_mask[m_sp] = act; m_kind[m_sp] = 1;
      end
    end else if (op == 2'b10 && m_kind[m_sp]) begin
      cur_req = "R8";
      m_kind[m_sp] = 0;
      b = m_sp - 1;
      m_pc[b] = first;
      m_sp = b;
      if (first == m_rpc[b] && !m_kind[b]) begin
        if (b == 0) e_unf = 1; else m_sp = b - 1;
      end
    end else begin
      cur_req = m_kind[m_sp] ? "R7" : (op == 2'b10 ? "R9" : "R3");
      g = 0; part = 0;
      for (int i = 0; i < L; i++) begin
        dup = 0;
        for (int j = 0; j < i; j++) if (act[j] && stim_pc[j] == stim_pc[i]) dup = 1;
        if (act[i] && !dup && !(!m_kind[m_sp] && stim_pc[i] == m_rpc[m_sp])) begin
          gp[g] = stim_pc[i]; gm[g] = '0;
          for (int j = 0; j < L; j++) if (act[j] && stim_pc[j] == stim_pc[i]) gm[g][j] = 1;
          if (gm[g] != act) part = 1;
          g++;
        end
      end
      if (g == 0) begin
        cur_req = "R5";
        if (m_sp == 0) begin e_unf = 1; cur_req = "R11"; end else m_sp--;
      end else if (!part) begin
        m_pc[m_sp] = gp[0];
      end else if (m_sp + g > D - 1) begin
        e_ovf = 1; cur_req = "R10";
      end else begin
        cur_req = "R4";
        m_pc[m_sp] = rv;
        for (int k = 0; k < g; k++) begin
          m_pc[m_sp+1+k] = gp[k]; m_rpc[m_sp+1+k] = rv; m_mask[m_sp+1+k] = gm[k]; m_kind[m_sp+1+k] = 0;
        end
        m_sp += g; e_div = 1;
      end
    end
  endtask

  task automatic do_update(logic [L-1:0] done, logic [W-1:0] rv, logic [1:0] op);
    @(negedge clk);
    for (int i = 0; i < L; i++) next_pc_i[i*W +: W] = stim_pc[i];
    done_mask_i = done; recv_pc_i = rv; op_i = op; upd_i = 1;
    m_update(done, rv, op);
    @(negedge clk);
    upd_i = 0;
  endtask

  task automatic do_launch(logic [W-1:0] pc, logic [L-1:0] mask);
    @(negedge clk);
    launch_i = 1; launch_pc_i = pc; launch_mask_i = mask;
    m_pc[0] = pc; m_rpc[0] = '1; m_mask[0] = mask; m_kind[0] = 0; m_sp = 0;
    e_div = 0; e_ovf = 0; e_unf = 0;
    @(negedge clk);
    launch_i = 0;
  endtask

  task automatic set_pcs(logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c, logic [W-1:0] d);
    stim_pc[0] = a; stim_pc[1] = b; stim_pc[2] = c; stim_pc[3] = d;
  endtask

  initial begin
    logic [W-1:0] pool[4];
    logic [1:0] rop;
    void'($urandom(32'h5eed1234));
    rst_n = 0; launch_i = 0; upd_i = 0; launch_pc_i = '0; launch_mask_i = '0;
    done_mask_i = '0; next_pc_i = '0; recv_pc_i = '0; op_i = '0;
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all("R1");
    chk("R1", "reset pc", 32'(top_pc_o), 32'h0000ffff);

    do_launch(16'h0100, 4'b1111);                 check_all("R2");
    set_pcs(16'h104, 16'h104, 16'h104, 16'h104);
    do_update(4'b0000, 16'h0200, 2'b00);          check_all("R3");
    chk("R3", "uniform pc", 32'(top_pc_o), 32'h104);
    set_pcs(16'h110, 16'h110, 16'h120, 16'h120);
    do_update(4'b0000, 16'h0130, 2'b00);          check_all("R4");
    chk("R4", "div depth", 32'(depth_o), 2);
    chk("R4", "div top mask", 32'(top_mask_o), 32'b1100);
    set_pcs(16'h130, 16'h130, 16'h130, 16'h130);
    do_update(4'b0000, 16'h0200, 2'b00);          check_all("R5");
    chk("R5", "reconv mask", 32'(top_mask_o), 32'b0011);
    set_pcs(16'h400, 16'h400, 16'h400, 16'h400);
    do_update(4'b0000, 16'h0000, 2'b01);          check_all("R6");
    chk("R6", "call flag", 32'(top_call_o), 1);
    set_pcs(16'hffff, 16'hffff, 16'hffff, 16'hffff);
    do_update(4'b0000, 16'h0000, 2'b00);          check_all("R7");
    chk("R7", "no drop depth", 32'(depth_o), 2);
    set_pcs(16'h130, 16'h130, 16'h130, 16'h130);
    do_update(4'b0000, 16'h0000, 2'b10);          check_all("R8");
    chk("R8", "double pop depth", 32'(depth_o), 0);
    set_pcs(16'h140, 16'h140, 16'h140, 16'h140);
    do_update(4'b0000, 16'h0000, 2'b10);          check_all("R9");
    chk("R9", "ret plain pc", 32'(top_pc_o), 32'h140);
    do_update(4'b1111, 16'h0000, 2'b00);          check_all("R11");
    chk("R11", "underflow", 32'(underflow_o), 1);
    do_launch(16'h0010, 4'b1111);
    set_pcs(16'h500, 16'h500, 16'h500, 16'h500);
    for (int n = 0; n < D - 1; n++) do_update(4'b0000, 16'h0, 2'b01);
    check_all("R6");
    do_update(4'b0000, 16'h0, 2'b01);             check_all("R10");
    chk("R10", "overflow", 32'(overflow_o), 1);

    // constrained random phase
    do_launch(16'h0010, 4'b1111);
    pool[0] = 16'h10; pool[1] = 16'h20; pool[2] = 16'h30; pool[3] = 16'h40;
    for (int n = 0; n < 1500; n++) begin
      if ($urandom_range(0, 39) == 0) begin
        do_launch(W'($urandom_range(0, 255)), L'($urandom_range(1, 15)));
        check_all("R2");
      end else begin
        for (int i = 0; i < L; i++)
          stim_pc[i] = ($urandom_range(0, 4) == 0) ? m_rpc[m_sp] : pool[$urandom_range(0, 3)];
        rop = 2'($urandom_range(0, 5));
        if (rop > 2'b11) rop = 2'b00;
        do_update(($urandom_range(0, 5) == 0) ? L'($urandom_range(0, 15)) : '0,
                  pool[$urandom_range(0, 3)] + 16'h100, rop);
        check_all(cur_req);
      end
    end
    report();
  end
endmodule